// File: doc/BRIEF.md
# Decoder Error Substitution and Status Flags

This block sits behind a four-lane 8b/10b decoder. Each lane delivers a decoded byte, a control-character flag and three error strobes: code violation, running-disparity error and clock-compensation FIFO error. The block passes the data stream on with one register of latency. Any character that carries a code violation is swapped for the error control character.

Disparity and FIFO errors are collected into a 16-bit status word of sticky per-lane flags. A management agent reads the word and pulses a read strobe, which clears the flags. A two-bit select steers live FIFO errors, loss-of-signal indications, or nothing onto four multifunction pins. While the codec is disabled, the lanes carry raw data. In that state no error source is active.

Top module: `dec_err_flagger`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, out_data, out_k, stat_word and mf_pins are all zero.
- R2: When codec_en is 1 and a lane's cv_err is 1, that lane's output one cycle later is byte 0xFE with its out_k bit set to 1.
- R3: When a lane has no code violation, its input byte and k flag appear unchanged on its output one cycle later.
- R4: With codec_en at 1, a disp_err pulse on lane i sets stat_word bit 8+i from the next cycle on, until it is cleared by a read.
- R5: With codec_en at 1, a fifo_err pulse on lane i sets stat_word bit 4+i from the next cycle on, until it is cleared by a read.
- R6: stat_word bits 15:12 and 3:0 always read zero.
- R7: A cycle with rd_clr at 1 clears every flag in the next cycle, except a flag whose error is present in that same cycle, which stays set.
- R8: When codec_en is 0, the inputs cv_err, disp_err and fifo_err have no effect: data passes unchanged, and flags are neither set nor cleared except by rd_clr.
- R9: With mf_sel = 1, mf_pins shows fifo_err one cycle later. The value is gated by codec_en, so it is zero while the codec is off.
- R10: With mf_sel = 2, mf_pins shows los one cycle later.
- R11: With mf_sel = 0 or 3, mf_pins is zero one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| codec_en | input | 1 | Decoder active; enables substitution and error flagging |
| in_data | input | 32 | Decoded bytes, lane i in bits 8i+7:8i |
| in_k | input | 4 | Control-character flag per lane |
| cv_err | input | 4 | Code-violation strobe per lane |
| disp_err | input | 4 | Disparity-error strobe per lane |
| fifo_err | input | 4 | Elastic FIFO error strobe per lane |
| los | input | 4 | Loss-of-signal indication per lane |
| mf_sel | input | 2 | Pin source: 0/3 off, 1 FIFO errors, 2 loss of signal |
| rd_clr | input | 1 | Status read strobe, clears flags |
| out_data | output | 32 | Substituted data, one cycle late |
| out_k | output | 4 | Control flag per lane, one cycle late |
| stat_word | output | 16 | Sticky flags: 11:8 disparity, 7:4 FIFO |
| mf_pins | output | 4 | Multifunction pin outputs |

## Verification
Every result goes through exactly one register, so a wrong next-state value shows up at the ports in the cycle right after the stimulus. A bad substitution appears as a wrong byte or k bit. A bad flag update appears as a status bit that is wrong on the following edge. Because the flags are sticky, a missed set or a lost clear stays visible until the next read. That makes the read-versus-error collision the case to watch. The bench sweeps every lane pattern under each codec state and each pin select, and checks the outputs against an arithmetic model after every edge.

// File: rtl/dec_err_pkg.sv
package dec_err_pkg;
    localparam int NUM_LANES = 4;
    localparam int BYTE_W    = 8;
    localparam int STAT_W    = 16;
    localparam int FIFO_LSB  = 4;
    localparam int DISP_LSB  = 8;
    localparam logic [BYTE_W-1:0] ERR_CHAR = 8'hFE;

    localparam logic [1:0] MF_NONE  = 2'd0;
    localparam logic [1:0] MF_FIFO  = 2'd1;
    localparam logic [1:0] MF_LOS   = 2'd2;
    localparam logic [1:0] MF_NONE2 = 2'd3;

    typedef struct packed {
        logic [BYTE_W-1:0] byte_v;
        logic              ctrl;
    } lane_st_t;

    typedef struct packed {
        logic [NUM_LANES-1:0] disp_f;
        logic [NUM_LANES-1:0] fifo_f;
    } flag_st_t;
endpackage

// File: rtl/dec_err_lane.sv
module dec_err_lane
    import dec_err_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              codec_en,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_ctrl,
    input  logic              cv,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_ctrl
);
    lane_st_t st_d, st_q;

    always_comb begin
        st_d.byte_v = in_byte;
        st_d.ctrl   = in_ctrl;
        if (codec_en && cv) begin
            st_d.byte_v = ERR_CHAR;
            st_d.ctrl   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_byte = st_q.byte_v;
    assign out_ctrl = st_q.ctrl;

    // R2
    err_subst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (codec_en && cv) |=> (out_byte == ERR_CHAR && out_ctrl));

    // R3
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(codec_en && cv) |=> (out_byte == $past(in_byte) && out_ctrl == $past(in_ctrl)));
endmodule

// File: rtl/dec_err_status.sv
module dec_err_status
    import dec_err_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 codec_en,
    input  logic                 rd_clr,
    input  logic [NUM_LANES-1:0] disp_err,
    input  logic [NUM_LANES-1:0] fifo_err,
    output logic [STAT_W-1:0]    stat_word
);
    localparam int LOW_PAD  = FIFO_LSB;
    localparam int HIGH_PAD = STAT_W - DISP_LSB - NUM_LANES;

    flag_st_t fl_d, fl_q;

    always_comb begin
        fl_d = rd_clr ? '0 : fl_q;
        if (codec_en) begin
            fl_d.disp_f = fl_d.disp_f | disp_err;
            fl_d.fifo_f = fl_d.fifo_f | fifo_err;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign stat_word = {{HIGH_PAD{1'b0}}, fl_q.disp_f, fl_q.fifo_f, {LOW_PAD{1'b0}}};

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_chk
        // R4
        disp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (codec_en && disp_err[i]) |=> stat_word[DISP_LSB+i]);
        // R5
        fifo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (codec_en && fifo_err[i]) |=> stat_word[FIFO_LSB+i]);
        // R7
        rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr && !(codec_en && disp_err[i])) |=> !stat_word[DISP_LSB+i]);
    end

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!codec_en && !rd_clr) |=> $stable(stat_word));
endmodule

// File: rtl/dec_err_mfmux.sv
module dec_err_mfmux
    import dec_err_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 codec_en,
    input  logic [1:0]           mf_sel,
    input  logic [NUM_LANES-1:0] fifo_err,
    input  logic [NUM_LANES-1:0] los,
    output logic [NUM_LANES-1:0] mf_pins
);
    logic [NUM_LANES-1:0] pin_d, pin_q;

    always_comb begin
        unique case (mf_sel)
            MF_FIFO: pin_d = codec_en ? fifo_err : '0;
            MF_LOS:  pin_d = los;
            default: pin_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_d;
    end

    assign mf_pins = pin_q;

    // R10
    los_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_sel == MF_LOS) |=> (mf_pins == $past(los)));

    // R11
    pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_sel == MF_NONE || mf_sel == MF_NONE2) |=> (mf_pins == '0));

    // R9
    fifo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_sel == MF_FIFO && !codec_en) |=> (mf_pins == '0));
endmodule

// File: rtl/dec_err_flagger.sv
module dec_err_flagger
    import dec_err_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        codec_en,
    input  logic [NUM_LANES*BYTE_W-1:0] in_data,
    input  logic [NUM_LANES-1:0]        in_k,
    input  logic [NUM_LANES-1:0]        cv_err,
    input  logic [NUM_LANES-1:0]        disp_err,
    input  logic [NUM_LANES-1:0]        fifo_err,
    input  logic [NUM_LANES-1:0]        los,
    input  logic [1:0]                  mf_sel,
    input  logic                        rd_clr,
    output logic [NUM_LANES*BYTE_W-1:0] out_data,
    output logic [NUM_LANES-1:0]        out_k,
    output logic [STAT_W-1:0]           stat_word,
    output logic [NUM_LANES-1:0]        mf_pins
);
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        dec_err_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .codec_en (codec_en),
            .in_byte  (in_data[i*BYTE_W +: BYTE_W]),
            .in_ctrl  (in_k[i]),
            .cv       (cv_err[i]),
            .out_byte (out_data[i*BYTE_W +: BYTE_W]),
            .out_ctrl (out_k[i])
        );
    end

    dec_err_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .codec_en  (codec_en),
        .rd_clr    (rd_clr),
        .disp_err  (disp_err),
        .fifo_err  (fifo_err),
        .stat_word (stat_word)
    );

    dec_err_mfmux u_mfmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .codec_en (codec_en),
        .mf_sel   (mf_sel),
        .fifo_err (fifo_err),
        .los      (los),
        .mf_pins  (mf_pins)
    );

    // R6
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[15:12] == 4'b0) && (stat_word[3:0] == 4'b0));
endmodule

// File: tb/test_dec_err_flagger.sv
module test_dec_err_flagger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        codec_en = 1'b0;
    logic [31:0] in_data = '0;
    logic [3:0]  in_k = '0, cv_err = '0, disp_err = '0, fifo_err = '0, los = '0;
    logic [1:0]  mf_sel = '0;
    logic        rd_clr = 1'b0;
    logic [31:0] out_data;
    logic [3:0]  out_k, mf_pins;
    logic [15:0] stat_word;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [3:0] m_disp = '0, m_fifo = '0;

    always #10 clk = ~clk;

    dec_err_flagger i_dec_err_flagger (
        .clk(clk), .rst_n(rst_n), .codec_en(codec_en), .in_data(in_data),
        .in_k(in_k), .cv_err(cv_err), .disp_err(disp_err), .fifo_err(fifo_err),
        .los(los), .mf_sel(mf_sel), .rd_clr(rd_clr), .out_data(out_data),
        .out_k(out_k), .stat_word(stat_word), .mf_pins(mf_pins)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drives one cycle of stimulus right after a falling edge, then checks at the next one.
    task automatic step(input logic en, input logic [1:0] sel, input logic [31:0] d,
                        input logic [3:0] k, input logic [3:0] cv, input logic [3:0] dp,
                        input logic [3:0] ff, input logic [3:0] ls, input logic rd);
        logic [3:0] e_disp, e_fifo, e_mf;
        logic [8:0] e_lane;
        codec_en = en; mf_sel = sel; in_data = d; in_k = k; cv_err = cv;
        disp_err = dp; fifo_err = ff; los = ls; rd_clr = rd;
        e_disp = (rd ? 4'b0 : m_disp) | (en ? dp : 4'b0);
        e_fifo = (rd ? 4'b0 : m_fifo) | (en ? ff : 4'b0);
        e_mf   = (sel == 2'd1) ? (en ? ff : 4'b0) : (sel == 2'd2) ? ls : 4'b0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            e_lane = (en && cv[i]) ? {8'hFE, 1'b1} : {d[i*8 +: 8], k[i]};
            chk({23'b0, out_data[i*8 +: 8], out_k[i]}, {23'b0, e_lane},
                (en && cv[i]) ? "R2" : (cv[i] ? "R8" : "R3"));
        end
        chk({28'b0, stat_word[11:8]}, {28'b0, e_disp}, !en ? "R8" : (rd ? "R7" : "R4"));
        chk({28'b0, stat_word[7:4]},  {28'b0, e_fifo}, !en ? "R8" : (rd ? "R7" : "R5"));
        chk({24'b0, stat_word[15:12], stat_word[3:0]}, 32'b0, "R6");
        chk({28'b0, mf_pins}, {28'b0, e_mf},
            (sel == 2'd1) ? "R9" : (sel == 2'd2) ? "R10" : "R11");
        m_disp = e_disp;
        m_fifo = e_fifo;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: drive busy inputs during reset, outputs must stay zero
        codec_en = 1'b1; in_data = 32'hDEADBEEF; in_k = 4'hF; cv_err = 4'hF;
        disp_err = 4'hF; fifo_err = 4'hF; los = 4'hF; mf_sel = 2'd2;
        repeat (3) @(negedge clk);
        chk(out_data, 32'b0, "R1");
        chk({12'b0, out_k, stat_word}, 32'b0, "R1");
        chk({28'b0, mf_pins}, 32'b0, "R1");
        codec_en = 1'b0; in_data = '0; in_k = '0; cv_err = '0; disp_err = '0;
        fifo_err = '0; los = '0; mf_sel = '0;
        @(negedge clk);
        rst_n = 1'b1;
        chk({12'b0, out_k, stat_word}, 32'b0, "R1");

        // R7 corner: error in the same cycle as the read survives it
        step(1, 0, 32'h0, 0, 0, 4'b0001, 4'b0010, 0, 0);
        step(1, 0, 32'h0, 0, 0, 4'b0001, 4'b0000, 0, 1);
        chk({31'b0, stat_word[8]}, 32'd1, "R7");
        step(1, 0, 32'h0, 0, 0, 0, 0, 0, 1);
        chk({16'b0, stat_word}, 32'b0, "R7");

        // Sweep codec state, pin select and lane patterns
        for (int en = 0; en < 2; en++)
            for (int sel = 0; sel < 4; sel++)
                for (int v = 0; v < 64; v++) begin
                    logic [31:0] d;
                    logic [3:0] lo;
                    lo = v[3:0];
                    for (int i = 0; i < 4; i++)
                        d[i*8 +: 8] = 8'((v * 37 + i * 61 + sel * 13) & 255);
                    step(en[0], sel[1:0], d, lo ^ v[5:2], lo, v[5:2] ^ 4'b0101,
                         ~lo & {v[4], v[1], v[5], v[0]}, v[5:2] ^ lo, (v % 5) == 0);
                end

        // R8: codec off with all strobes does not alter held flags
        step(1, 0, 32'h0, 0, 0, 4'b1010, 4'b0101, 0, 1);
        step(0, 1, 32'h12345678, 4'h3, 4'hF, 4'hF, 4'hF, 4'hF, 0);
        chk({16'b0, stat_word}, 32'h00000A50, "R8");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule